// File: doc/BRIEF.md
# ARINC 429 Word Transmitter with Eight-Word Queue

This block serialises 32-bit ARINC 429 words onto a pair of logic-level lines that feed the A and B sides of an external line driver. Software or a neighbouring block supplies each word as two 16-bit halfwords. The joined 31-bit payload goes into an eight-entry queue. While transmission is enabled, the block takes words from the head of the queue. For each word it sends the 31 payload bits and then a parity bit it generates itself. Every bit is return-to-zero: a data level for half the bit time, then null for the other half. A fixed null gap follows each word.

Halfwords arrive on a valid/ready stream. A halfword is taken on a clock edge where `hw_valid` and `hw_ready` are both high. The source must hold `hw_data` steady while `hw_valid` is high and `hw_ready` is low. `hw_ready` is low whenever all eight queue slots are occupied. The first accepted halfword of a pair is the low halfword and the second is the high halfword. The word joins the queue on the edge that accepts the second halfword.

The control pins are plain levels: transmit enable, parity sense and rate select. The single status pin, `tx_ready`, is high when the queue is empty and the serial line is idle. The bit clock is the master clock divided by 10 (fast rate) or 80 (slow rate).

Top module: `a429_xmit`

## Requirements
- R1: Payload bit mapping, where payload bit n is the nth bit on the line.
  - Low halfword: bus bits 7..0 carry payload bits 1..8 (bus bit 7 is payload bit 1), bus bits 11..15 carry payload bits 9..13, bus bit 9 carries bit 30 and bus bit 10 carries bit 31. Low halfword bus bit 8 is ignored.
  - High halfword: bus bits 0..15 carry payload bits 14..29.
- R2: The queue holds at most 8 words. While it holds 8, `hw_ready` is low and a presented halfword is not taken. The queued words are sent afterwards unchanged and in load order, and the refused word is never sent.
- R3: `tx_ready` is high after reset. It is low from the clock after a word completes loading. It returns high once the queue is empty and the gap after the last word has ended.
- R4: Bit 32 makes the count of ones in the 32 bits odd when `par_even` is 0 and even when it is 1. `par_even` is sampled when a word starts.
- R5: The line encoding is one = `line_a` high with `line_b` low; zero = `line_b` high with `line_a` low; null = both low. Both lines are never high together. Bits go out payload bit 1 first and bit 32 last.
- R6: At the fast rate (`slow_sel`=0, sampled at word start), each bit is 5 clocks of data level then 5 clocks of null. A 40-clock gap follows the word, so back-to-back words have 45 null clocks between the last bit's data level and the next word's first bit.
- R7: At the slow rate (`slow_sel`=1), each bit is 40 clocks of data level then 40 clocks of null, and the word gap is 320 clocks.
- R8: When enable is high, the line is idle and a word is queued, that word's first data level appears on the line one clock later. This is well inside 2.5 bit times.
- R9: If `tx_en` falls during a word, that word completes and is removed from the queue, and no further word starts. Raising `tx_en` again sends the next queued word.
- R10: Reset empties the queue, forgets a half-loaded pair, and holds both lines at null.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hw_valid | input | 1 | Halfword stream valid |
| hw_ready | output | 1 | Halfword stream ready (low when queue full) |
| hw_data | input | 16 | Halfword payload, low half first then high half |
| tx_en | input | 1 | Transmit enable level |
| par_even | input | 1 | Parity sense: 0 odd, 1 even |
| slow_sel | input | 1 | Rate select: 0 divide by 10, 1 divide by 80 |
| tx_ready | output | 1 | High when queue empty and line idle |
| line_a | output | 1 | High during a one data level |
| line_b | output | 1 | High during a zero data level |

## Verification
The bench fills the queue with eight distinct words and presents a ninth. A design that takes the ninth would overwrite a queued word or send nine words, and one with an off-by-one depth would refuse the eighth. It drops enable part-way through a word: a design that cut the word short would produce a truncated word, and one that kept draining would send the second word without enable. Words with every bus bit set, including the ignored bus position, and all-zero words under both parity senses catch mapping and parity-sense swaps. The bench also measures pulse widths, null widths and word gaps at both rates, which catches a half-period or gap-length error.

// File: rtl/a429_xmit_pkg.sv
package a429_xmit_pkg;
  localparam int PAYLOAD_W = 31;
  localparam int HALF_W    = 16;
  localparam int WORD_BITS = PAYLOAD_W + 1;

  typedef enum logic [1:0] {
    SER_IDLE = 2'd0,
    SER_SEND = 2'd1,
    SER_GAP  = 2'd2
  } ser_state_t;
endpackage

// File: rtl/a429_half_join.sv
module a429_half_join
  import a429_xmit_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hw_valid,
  output logic                 hw_ready,
  input  logic [HALF_W-1:0]    hw_data,
  input  logic                 q_full,
  output logic                 push,
  output logic [PAYLOAD_W-1:0] push_word
);
  logic              high_pending;
  logic [HALF_W-1:0] low_q;
  logic              take;

  assign hw_ready = !q_full;
  assign take     = hw_valid && hw_ready;
  assign push     = take && high_pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      high_pending <= 1'b0;
      low_q        <= '0;
    end else if (take) begin
      high_pending <= !high_pending;
      if (!high_pending) low_q <= hw_data;
    end
  end

  // index i of push_word is payload bit i+1
  always_comb begin
    for (int k = 0; k < 8; k++) push_word[k] = low_q[7-k];
    for (int m = 0; m < 5; m++) push_word[8+m] = low_q[11+m];
    for (int m = 0; m < 16; m++) push_word[13+m] = hw_data[m];
    push_word[29] = low_q[9];
    push_word[30] = low_q[10];
  end
endmodule

// File: rtl/a429_word_queue.sv
module a429_word_queue #(
  parameter int WIDTH = 31,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_word,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic             do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slots[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      if (do_push && !do_pop) level <= level + 1'b1;
      else if (do_pop && !do_push) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slots[wp] <= push_word;
  end
endmodule

// File: rtl/a429_symbol_seq.sv
module a429_symbol_seq
  import a429_xmit_pkg::*;
#(
  parameter int FAST_DIV = 10,
  parameter int SLOW_DIV = 80,
  parameter int GAP_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_en,
  input  logic                 slow_sel,
  input  logic                 par_even,
  input  logic [PAYLOAD_W-1:0] head,
  input  logic                 empty,
  output logic                 pop,
  output logic                 busy,
  output logic                 line_a,
  output logic                 line_b
);
  localparam int CW = $clog2(GAP_BITS * SLOW_DIV + 1);
  localparam int BW = $clog2(WORD_BITS);

  ser_state_t           state;
  logic [WORD_BITS-1:0] shreg;
  logic [CW-1:0]        cnt, bit_end, gap_end, half;
  logic [BW-1:0]        bidx;
  logic                 slow_q, can_start, at_bit_end, at_gap_end;

  always_comb begin
    bit_end = slow_q ? CW'(SLOW_DIV - 1) : CW'(FAST_DIV - 1);
    gap_end = slow_q ? CW'(GAP_BITS * SLOW_DIV - 1) : CW'(GAP_BITS * FAST_DIV - 1);
    half    = slow_q ? CW'(SLOW_DIV / 2) : CW'(FAST_DIV / 2);
  end

  assign at_bit_end = (cnt == bit_end);
  assign at_gap_end = (cnt == gap_end);
  assign can_start  = tx_en && !empty;
  assign pop  = can_start && ((state == SER_IDLE) || (state == SER_GAP && at_gap_end));
  assign busy = (state != SER_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SER_IDLE;
      shreg  <= '0;
      cnt    <= '0;
      bidx   <= '0;
      slow_q <= 1'b0;
    end else if (pop) begin
      state  <= SER_SEND;
      shreg  <= {par_even ~^ (^head), head};
      cnt    <= '0;
      bidx   <= '0;
      slow_q <= slow_sel;
    end else begin
      case (state)
        SER_SEND: begin
          if (at_bit_end) begin
            cnt <= '0;
            if (bidx == BW'(WORD_BITS - 1)) state <= SER_GAP;
            else begin
              bidx  <= bidx + 1'b1;
              shreg <= shreg >> 1;
            end
          end else cnt <= cnt + 1'b1;
        end
        SER_GAP: begin
          if (at_gap_end) state <= SER_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: cnt <= '0;
      endcase
    end
  end

  assign line_a = (state == SER_SEND) && (cnt < half) && shreg[0];
  assign line_b = (state == SER_SEND) && (cnt < half) && !shreg[0];
endmodule

// File: rtl/a429_xmit.sv
module a429_xmit
  import a429_xmit_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int FAST_DIV = 10,
  parameter int SLOW_DIV = 80,
  parameter int GAP_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hw_valid,
  output logic        hw_ready,
  input  logic [15:0] hw_data,
  input  logic        tx_en,
  input  logic        par_even,
  input  logic        slow_sel,
  output logic        tx_ready,
  output logic        line_a,
  output logic        line_b
);
  localparam int LW = $clog2(DEPTH + 1);

  logic                 push, pop, q_full, q_empty, ser_busy;
  logic [PAYLOAD_W-1:0] push_word, head;
  logic [LW-1:0]        q_level;

  a429_half_join u_join (
    .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_ready(hw_ready),
    .hw_data(hw_data), .q_full(q_full), .push(push), .push_word(push_word)
  );

  a429_word_queue #(.WIDTH(PAYLOAD_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push), .push_word(push_word), .pop(pop),
    .head(head), .full(q_full), .empty(q_empty), .level(q_level)
  );

  a429_symbol_seq #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .GAP_BITS(GAP_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .slow_sel(slow_sel), .par_even(par_even),
    .head(head), .empty(q_empty), .pop(pop), .busy(ser_busy),
    .line_a(line_a), .line_b(line_b)
  );

  assign tx_ready = q_empty && !ser_busy;
endmodule

// File: rtl/a429_xmit_chk.sv
module a429_xmit_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       line_a,
  input logic                       line_b,
  input logic                       tx_ready,
  input logic                       tx_en,
  input logic                       hw_valid,
  input logic                       hw_ready,
  input logic [$clog2(DEPTH+1)-1:0] q_level,
  input logic                       pop
);
  assert_lines_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_a && line_b));

  assert_ready_null_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!line_a && !line_b));

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= ($clog2(DEPTH+1))'(DEPTH));

  assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_level == ($clog2(DEPTH+1))'(DEPTH) && !pop) |=> (q_level == ($clog2(DEPTH+1))'(DEPTH)));

  assert_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && tx_ready) |=> (!line_a && !line_b));

  assert_after_reset_R10: assert property (@(posedge clk)
    (!rst_n) |=> (!line_a && !line_b && tx_ready));
endmodule

bind a429_xmit a429_xmit_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b), .tx_ready(tx_ready),
  .tx_en(tx_en), .hw_valid(hw_valid), .hw_ready(hw_ready), .q_level(q_level), .pop(pop)
);

// File: tb/a429_xmit_tb.sv
`timescale 1ns/1ps
module a429_xmit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hw_valid = 1'b0, tx_en = 1'b0, par_even = 1'b0, slow_sel = 1'b0;
  logic [15:0] hw_data = '0;
  logic hw_ready, tx_ready, line_a, line_b;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  a429_xmit dut_i (.*);

  // {low half, high half, par_even, slow_sel}
  localparam logic [33:0] VEC [6] = '{
    {16'hA5C3, 16'h1234, 1'b0, 1'b0},
    {16'hFFFF, 16'hFFFF, 1'b0, 1'b0},
    {16'h0000, 16'h0000, 1'b1, 1'b0},
    {16'h5A00, 16'h8001, 1'b1, 1'b0},
    {16'h0F80, 16'hCAFE, 1'b0, 1'b1},
    {16'hF07F, 16'h0F0F, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic [15:0] lo, input logic [15:0] hi, input logic pe);
    logic [31:0] w;
    w = '0;
    for (int k = 1; k <= 8; k++) w[k-1] = lo[8-k];
    w[8] = lo[11]; w[9] = lo[12]; w[10] = lo[13]; w[11] = lo[14]; w[12] = lo[15];
    w[29] = lo[9]; w[30] = lo[10];
    for (int b = 14; b <= 29; b++) w[b-1] = hi[b-14];
    w[31] = pe ? ($countones(w[30:0]) % 2 == 1) : ($countones(w[30:0]) % 2 == 0);
    return w;
  endfunction

  task automatic send_half(input logic [15:0] d);
    hw_valid = 1'b1; hw_data = d;
    while (!hw_ready) @(negedge clk);
    @(negedge clk);
    hw_valid = 1'b0;
  endtask

  task automatic load(input logic [15:0] lo, input logic [15:0] hi);
    send_half(lo); send_half(hi);
  endtask

  function automatic bit active();
    return line_a || line_b;
  endfunction

  // waits for the first data level, then reads 32 bits; ends on first null clock after bit 32
  task automatic grab(input int half, output logic [31:0] w, output int terr);
    int t, c;
    terr = 0; w = '0; t = 0;
    while (!active() && t < 5000) begin @(negedge clk); t++; end
    if (!active()) begin terr = 1000; return; end
    for (int i = 0; i < 32; i++) begin
      w[i] = line_a;
      if (line_a && line_b) terr++;
      c = 0;
      while (active() && c < 500) begin @(negedge clk); c++; end
      if (c != half) terr++;
      if (i < 31) begin
        c = 0;
        while (!active() && c < 500) begin @(negedge clk); c++; end
        if (c != half) terr++;
      end
    end
  endtask

  task automatic quiet(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (active()) hits++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] got, exp;
    int terr, hits, lat, half, gap;
    logic [15:0] lo8 [8], hi8 [8];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 / R3 reset state
    chk(tx_ready == 1'b1, "R3 ready after reset", 32'(tx_ready), 32'd1);
    chk(!line_a && !line_b, "R10 lines null after reset", {30'd0, line_a, line_b}, 32'd0);
    chk(hw_ready == 1'b1, "R2 ready to take halfword after reset", 32'(hw_ready), 32'd1);

    // table walk: R1 R4 R5 R6 R7 R3
    foreach (VEC[v]) begin
      par_even = VEC[v][1]; slow_sel = VEC[v][0];
      half = slow_sel ? 40 : 5;
      load(VEC[v][33:18], VEC[v][17:2]);
      chk(tx_ready == 1'b0, "R3 ready low after load", 32'(tx_ready), 32'd0);
      tx_en = 1'b1;
      exp = expect_word(VEC[v][33:18], VEC[v][17:2], VEC[v][1]);
      grab(half, got, terr);
      chk(got == exp, "R1 R4 R5 word content", got, exp);
      chk(terr == 0, slow_sel ? "R7 slow bit timing" : "R6 fast bit timing", 32'(terr), 32'd0);
      chk($countones(got) % 2 == (VEC[v][1] ? 0 : 1), "R4 parity sense", got, exp);
      tx_en = 1'b0;
      repeat (half + (slow_sel ? 320 : 40) + 2) @(negedge clk);
      chk(tx_ready == 1'b1, "R3 ready after gap", 32'(tx_ready), 32'd1);
    end

    // R8 start latency and R9 enable drop mid-word
    par_even = 1'b0; slow_sel = 1'b0;
    load(16'h1357, 16'h2468);
    load(16'hBEEF, 16'h7531);
    @(negedge clk);
    tx_en = 1'b1; lat = 0;
    while (!active() && lat < 100) begin @(negedge clk); lat++; end
    chk(lat == 1, "R8 first bit latency", 32'(lat), 32'd1);
    tx_en = 1'b0;
    grab(5, got, terr);
    exp = expect_word(16'h1357, 16'h2468, 1'b0);
    chk(got == exp && terr == 0, "R9 current word completes", got, exp);
    quiet(600, hits);
    chk(hits == 0, "R9 no further word after enable drop", 32'(hits), 32'd0);
    chk(tx_ready == 1'b0, "R9 queued word kept", 32'(tx_ready), 32'd0);
    tx_en = 1'b1;
    grab(5, got, terr);
    exp = expect_word(16'hBEEF, 16'h7531, 1'b0);
    chk(got == exp, "R9 next word after re-enable", got, exp);
    tx_en = 1'b0;
    repeat (60) @(negedge clk);

    // R6 back-to-back gap
    load(16'h0101, 16'hFFFE);
    load(16'h8080, 16'h0001);
    tx_en = 1'b1;
    grab(5, got, terr);
    gap = 0;
    while (!active() && gap < 500) begin @(negedge clk); gap++; end
    chk(gap == 45, "R6 null clocks between words", 32'(gap), 32'd45);
    grab(5, got, terr);
    exp = expect_word(16'h8080, 16'h0001, 1'b0);
    chk(got == exp && terr == 0, "R6 second word", got, exp);
    tx_en = 1'b0;
    repeat (60) @(negedge clk);

    // R2 fill to eight, refuse ninth, drain in order
    for (int i = 0; i < 8; i++) begin
      lo8[i] = {4'(i), 12'h3A5};
      hi8[i] = 16'h1000 ^ (16'h0101 * 16'(i));
      load(lo8[i], hi8[i]);
    end
    chk(hw_ready == 1'b0, "R2 ready low when full", 32'(hw_ready), 32'd0);
    hw_valid = 1'b1; hw_data = 16'hDEAD;
    repeat (5) @(negedge clk);
    hw_valid = 1'b0;
    tx_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      grab(5, got, terr);
      exp = expect_word(lo8[i], hi8[i], 1'b0);
      chk(got == exp, "R2 queued order", got, exp);
    end
    quiet(600, hits);
    chk(hits == 0, "R2 refused word never sent", 32'(hits), 32'd0);
    chk(tx_ready == 1'b1, "R3 ready after drain", 32'(tx_ready), 32'd1);
    tx_en = 1'b0;

    // R10 reset clears queue and half-loaded pair
    load(16'h4444, 16'h5555);
    send_half(16'h6666);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R10 queue empty after reset", 32'(tx_ready), 32'd1);
    tx_en = 1'b1;
    quiet(100, hits);
    chk(hits == 0, "R10 nothing sent after reset", 32'(hits), 32'd0);
    load(16'h00FF, 16'hA00A);
    grab(5, got, terr);
    exp = expect_word(16'h00FF, 16'hA00A, 1'b0);
    chk(got == exp, "R10 pair phase restarts at low half", got, exp);
    tx_en = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule